// File: doc/BRIEF.md
# Offset Calibration Sequencer with Black-Level Clamp

This block is the control part of an analog front end's offset loop. A control register bit holds the front end in a reset mode. When software clears that bit, the sequencer starts a calibration by itself. For a fixed number of converter clock cycles it nudges a signed correction term one step per cycle. Each step moves the digitised sample toward the black-level target. The target is the programmed clamp value. When the window ends, the correction is frozen.

The code sent to the offset DAC is always the frozen or running correction plus the clamp setting. The clamp setting is first limited to its legal band. The sum saturates at the DAC code limits. A busy flag is high for exactly the calibration window. Setting the reset-mode bit again discards the correction, and the next release starts a new calibration.

Top module: `offset_cal_sequencer`

## Requirements
- R1: While `cal_hold` is 1 (and after `rst_n` low), from the next cycle `cal_busy` is 0 and the correction is zero, so `dac_code` equals the limited clamp value.
- R2: The first rising clock edge that sees `cal_hold` at 0 after a hold or reset sets `cal_busy` to 1.
- R3: `cal_busy` stays 1 for exactly `CAL_CYCLES` (default 40000) cycles, then goes to 0. It does not rise again until `cal_hold` has been set and cleared.
- R4: On each cycle with `cal_busy` at 1, the correction moves by +1 when `adc_code` is below the limited clamp value and by -1 when it is above. It is unchanged when the two are equal.
- R5: Once `cal_busy` has fallen, the correction stays frozen whatever `adc_code` does, so `dac_code` changes only through `clamp_set`.
- R6: The clamp value used is `clamp_set` limited to the range 14..76: below 14 reads as 14, above 76 reads as 76.
- R7: `dac_code` is the limited clamp value plus the signed correction, saturated to 0..2^CODE_W-1 (0..1023 by default) instead of wrapping.
- R8: The correction itself saturates at the limits of its signed `CORR_W`-bit range (default -1024..1023) and never wraps.
- R9: Setting `cal_hold` to 1 in the middle of a calibration clears the correction and `cal_busy` on the next cycle. The next release runs a complete window of `CAL_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_hold | input | 1 | Reset-mode register bit; 1 holds, falling to 0 starts calibration |
| adc_code | input | CODE_W | Digitised sample seen through the offset loop |
| clamp_set | input | CLAMP_W | Black-level clamp register value in LSB |
| dac_code | output | CODE_W | Offset DAC input: clamp plus correction, saturated |
| cal_busy | output | 1 | High during the calibration window |

## Verification
A faulty window counter shows up as a wrong `cal_busy` length, visible when the busy pulse ends roughly 40000 cycles after release. A wrong start condition is visible one cycle after release. A correction register that steps the wrong way or fails to freeze shows at `dac_code` within a cycle of the step, and as a final DAC value that does not bring the modelled sample back to the clamp target. A wrapping correction or sum shows as `dac_code` jumping to the opposite end of its range when a large plant offset drives the loop into saturation. Clamp limiting is seen directly at `dac_code` as soon as `clamp_set` changes.

// File: rtl/offcal_pkg.sv
// Shared types for the offset calibration sequencer.
package offcal_pkg;
    typedef enum logic [1:0] {
        SEQ_ARMED = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_t;
endpackage

// File: rtl/cal_window_timer.sv
// Calibration window timer.
// Arms while the hold bit is set, opens a window of exactly CAL_CYCLES cycles
// on the first edge that sees hold low, then rests until hold is set again.
// Assumes hold is synchronous to clk.
module cal_window_timer
    import offcal_pkg::*;
#(
    parameter int CAL_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic busy
);
    localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Sequence arm -> run -> done, with cycle counting inside the run phase.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state <= SEQ_ARMED;
            cnt   <= '0;
        end else begin
            unique case (state)
                SEQ_ARMED: begin
                    state <= SEQ_RUN;
                    cnt   <= '0;
                end
                SEQ_RUN: begin
                    if (cnt == LAST) begin
                        state <= SEQ_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_DONE;
            endcase
        end
    end

    assign busy = (state == SEQ_RUN);

    // R1 / R9: hold forces the flag low on the next cycle.
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !busy);

    // R2: release from the armed state opens the window.
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && state == SEQ_ARMED) |=> busy);

    // R3: the counter never passes the window length while busy.
    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));

    // R3: no restart without a new hold.
    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_DONE && !hold) |=> !busy);
endmodule

// File: rtl/cal_step_tracker.sv
// Correction accumulator.
// Steps a signed correction by one LSB per enabled cycle toward the point
// where the sample equals the target, saturating at its signed range.
// Clear has priority over enable; assumes the sample already reflects the
// current correction (one-cycle loop).
module cal_step_tracker
    import offcal_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int CORR_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     enable,
    input  logic [CODE_W-1:0]        sample,
    input  logic [CODE_W-1:0]        target,
    output logic signed [CORR_W-1:0] corr
);
    localparam logic signed [CORR_W-1:0] CORR_MAX = {1'b0, {(CORR_W-1){1'b1}}};
    localparam logic signed [CORR_W-1:0] CORR_MIN = {1'b1, {(CORR_W-1){1'b0}}};
    localparam logic signed [CORR_W-1:0] CORR_ONE = CORR_W'(1);

    step_dir_t dir;

    // Pick the step direction from the sample-versus-target comparison.
    always_comb begin
        if (sample > target)      dir = DIR_DOWN;
        else if (sample < target) dir = DIR_UP;
        else                      dir = DIR_HOLD;
    end

    // Update the correction with saturation; frozen when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            corr <= '0;
        end else if (enable) begin
            unique case (dir)
                DIR_UP:   if (corr != CORR_MAX) corr <= corr + CORR_ONE;
                DIR_DOWN: if (corr != CORR_MIN) corr <= corr - CORR_ONE;
                default:  corr <= corr;
            endcase
        end
    end

    // R9: clear empties the correction on the next cycle.
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (corr == '0));

    // R4: an enabled cycle moves the correction by at most one LSB.
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clear) |=> (corr == $past(corr) ||
                                corr == $past(corr) + CORR_ONE ||
                                corr == $past(corr) - CORR_ONE));

    // R5: outside the window the correction does not move.
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(corr));

    // R8: at the top of the range the correction never wraps to the bottom.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (corr == CORR_MAX && !clear) |=> (corr != CORR_MIN));
endmodule

// File: rtl/clamp_sum.sv
// Clamp limiter and saturating DAC summer.
// Limits the clamp register to [CLAMP_MIN, CLAMP_MAX] and adds the signed
// correction, saturating at the unsigned CODE_W-bit DAC range.
// Purely combinational; assumes CODE_W > CLAMP_W.
module clamp_sum #(
    parameter int CODE_W    = 10,
    parameter int CLAMP_W   = 7,
    parameter int CORR_W    = 11,
    parameter int CLAMP_MIN = 14,
    parameter int CLAMP_MAX = 76
) (
    input  logic [CLAMP_W-1:0]       clamp_raw,
    input  logic signed [CORR_W-1:0] corr,
    output logic [CODE_W-1:0]        clamp_eff,
    output logic [CODE_W-1:0]        dac
);
    localparam int SUM_W = ((CORR_W > CODE_W) ? CORR_W : CODE_W) + 2;
    localparam logic [CLAMP_W-1:0]      LO      = CLAMP_W'(CLAMP_MIN);
    localparam logic [CLAMP_W-1:0]      HI      = CLAMP_W'(CLAMP_MAX);
    localparam logic signed [SUM_W-1:0] DAC_TOP = SUM_W'((2 ** CODE_W) - 1);

    logic [CLAMP_W-1:0]      clip;
    logic signed [SUM_W-1:0] sum;

    // Limit the clamp setting to its legal band.
    always_comb begin
        if (clamp_raw < LO)      clip = LO;
        else if (clamp_raw > HI) clip = HI;
        else                     clip = clamp_raw;
    end

    assign clamp_eff = {{(CODE_W-CLAMP_W){1'b0}}, clip};

    // Add the correction and saturate to the DAC code range.
    always_comb begin
        sum = SUM_W'(signed'({1'b0, clamp_eff})) + SUM_W'(corr);
        if (sum < 0)            dac = '0;
        else if (sum > DAC_TOP) dac = '1;
        else                    dac = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/offset_cal_sequencer.sv
// Offset calibration sequencer with black-level clamp (top).
// Runs a fixed-length calibration after the reset-mode bit is released,
// freezes the correction, and drives the DAC with clamp plus correction.
// Assumes adc_code already reflects the previous cycle's dac_code.
module offset_cal_sequencer #(
    parameter int CODE_W     = 10,
    parameter int CLAMP_W    = 7,
    parameter int CORR_W     = 11,
    parameter int CLAMP_MIN  = 14,
    parameter int CLAMP_MAX  = 76,
    parameter int CAL_CYCLES = 40000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cal_hold,
    input  logic [CODE_W-1:0]  adc_code,
    input  logic [CLAMP_W-1:0] clamp_set,
    output logic [CODE_W-1:0]  dac_code,
    output logic               cal_busy
);
    logic signed [CORR_W-1:0] corr;
    logic [CODE_W-1:0]        target;

    cal_window_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cal_hold),
        .busy  (cal_busy)
    );

    cal_step_tracker #(.CODE_W(CODE_W), .CORR_W(CORR_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cal_hold),
        .enable (cal_busy),
        .sample (adc_code),
        .target (target),
        .corr   (corr)
    );

    clamp_sum #(
        .CODE_W    (CODE_W),
        .CLAMP_W   (CLAMP_W),
        .CORR_W    (CORR_W),
        .CLAMP_MIN (CLAMP_MIN),
        .CLAMP_MAX (CLAMP_MAX)
    ) u_sum (
        .clamp_raw (clamp_set),
        .corr      (corr),
        .clamp_eff (target),
        .dac       (dac_code)
    );

    // R1: a cycle after hold the DAC carries the limited clamp only.
    p_hold_dac_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_hold && $stable(clamp_set)) |=> (dac_code == target));
endmodule

// File: tb/sim_offset_cal_sequencer.sv
module sim_offset_cal_sequencer;
    localparam int CAL = 40000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_hold = 1'b1;
    logic [6:0] clamp_set = 7'd50;
    logic [9:0] adc_code;
    logic [9:0] dac_code;
    logic       cal_busy;
    int         plant_off = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    offset_cal_sequencer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_hold  (cal_hold),
        .adc_code  (adc_code),
        .clamp_set (clamp_set),
        .dac_code  (dac_code),
        .cal_busy  (cal_busy)
    );

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int exp_clamp(int c);
        return lim(c, 14, 76);
    endfunction

    function automatic int exp_dac(int c, int corr);
        return lim(exp_clamp(c) + corr, 0, 1023);
    endfunction

    // Plant: sample follows the DAC code plus a fixed offset, clipped.
    assign adc_code = 10'(lim(int'(dac_code) + plant_off, 0, 1023));

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Release hold and follow one full window; returns busy length.
    task automatic run_cal(int c, int off, output int len, output int d1, output int d11);
        @(negedge clk);
        clamp_set = 7'(c);
        plant_off = off;
        cal_hold  = 1'b0;
        @(negedge clk);
        chk("R2 busy after release", int'(cal_busy), 1);
        len = 0; d1 = 0; d11 = 0;
        while (cal_busy) begin
            len++;
            if (len == 1)  d1  = int'(dac_code);
            if (len == 11) d11 = int'(dac_code);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 195000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int len, d1, d11, c;
        void'($urandom(32'd2718));

        // Reset state and clamp limits while held (R1, R6).
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy in hold", int'(cal_busy), 0);
        chk("R1 dac in hold", int'(dac_code), 50);
        clamp_set = 7'd5;
        @(negedge clk);
        chk("R6 low clamp limit", int'(dac_code), 14);
        clamp_set = 7'd120;
        @(negedge clk);
        chk("R6 high clamp limit", int'(dac_code), 76);

        // Normal calibration: clamp 40, plant offset -120 (R2, R3, R4).
        run_cal(40, -120, len, d1, d11);
        chk("R3 window length", len, CAL);
        chk("R4 first dac", d1, 40);
        chk("R4 ten up-steps", d11, 50);
        chk("R4 converged dac", int'(dac_code), 160);
        chk("R4 sample at target", int'(adc_code), 40);
        repeat (5) @(negedge clk);
        chk("R3 no restart", int'(cal_busy), 0);

        // Frozen correction +120 under random and directed clamps (R5, R6, R7).
        for (int i = 0; i < 24; i++) begin
            c = (i == 0) ? 3 : ((i == 1) ? 127 : int'($urandom_range(0, 127)));
            clamp_set = 7'(c);
            repeat (3) @(negedge clk);
            chk("R5 frozen dac vs clamp", int'(dac_code), exp_dac(c, 120));
        end

        // Abort mid-window, then a full restart (R9, R1).
        @(negedge clk);
        cal_hold = 1'b1;
        @(negedge clk);
        clamp_set = 7'd60;
        plant_off = 25;
        cal_hold  = 1'b0;
        repeat (50) @(negedge clk);
        chk("R9 busy mid window", int'(cal_busy), 1);
        chk("R4 down-converged dac", int'(dac_code), 35);
        cal_hold = 1'b1;
        @(negedge clk);
        chk("R9 busy cleared", int'(cal_busy), 0);
        chk("R9 correction cleared", int'(dac_code), 60);
        repeat (3) @(negedge clk);
        run_cal(60, 25, len, d1, d11);
        chk("R9 full window after restart", len, CAL);
        chk("R4 restart converged dac", int'(dac_code), 35);

        // Low saturation: correction driven to its minimum (R7, R8).
        @(negedge clk);
        cal_hold = 1'b1;
        repeat (2) @(negedge clk);
        run_cal(76, 300, len, d1, d11);
        chk("R7 dac floor", int'(dac_code), 0);
        clamp_set = 7'd14;
        @(negedge clk);
        chk("R8 no wrap at minimum", int'(dac_code), 0);

        // High saturation: correction driven to its maximum (R7, R8).
        cal_hold = 1'b1;
        repeat (2) @(negedge clk);
        run_cal(50, -1000, len, d1, d11);
        chk("R7 dac ceiling", int'(dac_code), 1023);
        clamp_set = 7'd14;
        @(negedge clk);
        chk("R8 no wrap at maximum", int'(dac_code), 1023);

        finish_run();
    end
endmodule